// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block works out the next program counter for a 32-bit RISC core. It is purely combinational. Its inputs are the address of the current instruction, the instruction's 26-bit jump offset, its 16-bit immediate, the value read from source register s1 and a control-flow operation select. From these it gives the next PC and a taken flag. It also gives a link-write request with its destination index and value, and a flag that marks a misaligned target.

Relative jumps add the sign-extended 26-bit offset to the sequential address. Conditional branches add the sign-extended 16-bit immediate to the same base, and they are taken only when s1 passes a zero test. Register jumps go to the address held in s1. The two linking forms also ask for the sequential address to be written to register 31. The sequential address is the current PC plus 4, and all address arithmetic wraps modulo 2^32. The surrounding pipeline decodes the operation, reads the register file and acts on the outputs.

Top module: `npc_unit`

## Requirements
- R1: The operation select `op_i` is encoded as 0 none, 1 relative jump, 2 relative jump with link, 3 register jump, 4 register jump with link, 5 branch-if-zero and 6 branch-if-nonzero. For op 0, `next_pc_o` is `pc_i + 4` and `taken_o` is 0.
- R2: For op 1 and op 2, `taken_o` is 1 and `next_pc_o` is `pc_i + 4` plus `offset_i` sign-extended from bit 25.
- R3: For op 3 and op 4, `taken_o` is 1 and `next_pc_o` equals `rs1_i`.
- R4: For op 5, `taken_o` is 1 exactly when `rs1_i` is zero. When taken, `next_pc_o` is `pc_i + 4` plus `imm_i` sign-extended from bit 15. Otherwise it is `pc_i + 4`.
- R5: For op 6, `taken_o` is 1 exactly when `rs1_i` is nonzero. The target is the one R4 gives. When not taken, `next_pc_o` is `pc_i + 4`.
- R6: `link_we_o` is 1 only for op 2 and op 4. `link_idx_o` is always 31. `link_val_o` is always `pc_i + 4`.
- R7: `misalign_o` is 1 exactly when `taken_o` is 1 and bits [1:0] of `next_pc_o` are not both zero.
- R8: All address sums wrap modulo 2^32. For example, `pc_i` = 0xFFFFFFFC with op 0 gives `next_pc_o` = 0.
- R9: Op code 7 is reserved. It behaves as op 0: not taken, no link write, no misaligned flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| offset_i | input | 26 | Relative jump offset field |
| imm_i | input | 16 | Branch immediate field |
| rs1_i | input | 32 | Value of source register s1 |
| op_i | input | 3 | Control-flow operation select |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Control transfer occurs |
| link_we_o | output | 1 | Request to write the link register |
| link_idx_o | output | 5 | Link register index (31) |
| link_val_o | output | 32 | Return address to link |
| misalign_o | output | 1 | Taken target is not word aligned |

## Verification
The bound checker evaluates these relations on every input change:
- An untaken result always falls through to `pc_i + 4`.
- Register jumps land exactly on `rs1_i`.
- The two branch forms follow the zero test of `rs1_i`.
- The link outputs follow the linking operations.
- The misaligned flag agrees with the taken target.
- The reserved code stays inert.

The exact relative targets need the bench's scenarios to show them. These include wrap-around across the top of the address space, extreme negative offsets and immediates, and misaligned targets on each path. The bench compares every output against an independent model for each vector.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [2:0] {
      CF_NONE       = 3'd0,
      CF_JUMP       = 3'd1,
      CF_JUMP_LINK  = 3'd2,
      CF_JREG       = 3'd3,
      CF_JREG_LINK  = 3'd4,
      CF_BR_ZERO    = 3'd5,
      CF_BR_NONZERO = 3'd6
   } cf_op_e;

   typedef struct packed {
      logic rel_long;   // base + long offset
      logic reg_ind;    // target from s1
      logic branch;     // conditional on zero test
      logic want_zero;  // branch condition polarity
      logic link;       // write return address
   } cf_ctl_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [2:0] op_i,
   output cf_ctl_t    ctl_o
);

   always_comb begin
      ctl_o = '0;
      case (op_i)
         CF_JUMP:       ctl_o.rel_long = 1'b1;
         CF_JUMP_LINK: begin
            ctl_o.rel_long = 1'b1;
            ctl_o.link     = 1'b1;
         end
         CF_JREG:       ctl_o.reg_ind = 1'b1;
         CF_JREG_LINK: begin
            ctl_o.reg_ind = 1'b1;
            ctl_o.link    = 1'b1;
         end
         CF_BR_ZERO: begin
            ctl_o.branch    = 1'b1;
            ctl_o.want_zero = 1'b1;
         end
         CF_BR_NONZERO: ctl_o.branch = 1'b1;
         default:       ctl_o = '0;
      endcase
   end

endmodule

// File: rtl/npc_sext_add.sv
module npc_sext_add #(
   parameter int XLEN   = 32,
   parameter int FIELD_W = 16
) (
   input  logic [XLEN-1:0]    base_i,
   input  logic [FIELD_W-1:0] field_i,
   output logic [XLEN-1:0]    sum_o
);

   localparam int EXT_W = XLEN - FIELD_W;

   logic [XLEN-1:0] field_ext;

   generate
      if (FIELD_W < 1 || FIELD_W > XLEN) begin : g_bad
         $error("npc_sext_add: FIELD_W must lie in 1..XLEN");
      end
      if (EXT_W > 0) begin : g_extend
         assign field_ext = {{EXT_W{field_i[FIELD_W-1]}}, field_i};
      end else begin : g_plain
         assign field_ext = field_i[XLEN-1:0];
      end
   endgenerate

   assign sum_o = base_i + field_ext;

endmodule

// File: rtl/npc_align_chk.sv
module npc_align_chk #(
   parameter int XLEN       = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic [XLEN-1:0] addr_i,
   input  logic            taken_i,
   output logic            misalign_o
);

   generate
      if (ALIGN_BITS < 0 || ALIGN_BITS >= XLEN) begin : g_bad
         $error("npc_align_chk: ALIGN_BITS out of range");
      end
      if (ALIGN_BITS == 0) begin : g_none
         assign misalign_o = 1'b0;
      end else begin : g_check
         assign misalign_o = taken_i && (addr_i[ALIGN_BITS-1:0] != '0);
      end
   endgenerate

   logic unused_addr;
   assign unused_addr = ^addr_i;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int OFS_W       = 26,
   parameter int IMM_W       = 16,
   parameter int IDX_W       = 5,
   parameter int LINK_REG    = 31,
   parameter int INSTR_BYTES = 4,
   parameter int ALIGN_BITS  = 2
) (
   input  logic [XLEN-1:0]  pc_i,
   input  logic [OFS_W-1:0] offset_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [XLEN-1:0]  rs1_i,
   input  logic [2:0]       op_i,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             taken_o,
   output logic             link_we_o,
   output logic [IDX_W-1:0] link_idx_o,
   output logic [XLEN-1:0]  link_val_o,
   output logic             misalign_o
);

   localparam logic [XLEN-1:0]  STEP     = XLEN'(INSTR_BYTES);
   localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);

   generate
      if (LINK_REG >= (1 << IDX_W)) begin : g_bad_link
         $error("npc_unit: LINK_REG does not fit in IDX_W bits");
      end
      if (OFS_W > XLEN || IMM_W > XLEN) begin : g_bad_field
         $error("npc_unit: offset fields wider than XLEN");
      end
   endgenerate

   cf_ctl_t         ctl;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] jump_tgt;
   logic [XLEN-1:0] br_tgt;
   logic            s1_zero;
   logic            br_take;

   npc_decode u_dec (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   assign seq_pc = pc_i + STEP;

   npc_sext_add #(.XLEN(XLEN), .FIELD_W(OFS_W)) u_jump_add (
      .base_i  (seq_pc),
      .field_i (offset_i),
      .sum_o   (jump_tgt)
   );

   npc_sext_add #(.XLEN(XLEN), .FIELD_W(IMM_W)) u_br_add (
      .base_i  (seq_pc),
      .field_i (imm_i),
      .sum_o   (br_tgt)
   );

   assign s1_zero = (rs1_i == '0);
   assign br_take = ctl.branch && (s1_zero == ctl.want_zero);

   always_comb begin
      next_pc_o = seq_pc;
      taken_o   = 1'b0;
      if (ctl.rel_long) begin
         next_pc_o = jump_tgt;
         taken_o   = 1'b1;
      end else if (ctl.reg_ind) begin
         next_pc_o = rs1_i;
         taken_o   = 1'b1;
      end else if (br_take) begin
         next_pc_o = br_tgt;
         taken_o   = 1'b1;
      end
   end

   assign link_we_o  = ctl.link;
   assign link_idx_o = LINK_IDX;
   assign link_val_o = seq_pc;

   npc_align_chk #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_align (
      .addr_i     (next_pc_o),
      .taken_i    (taken_o),
      .misalign_o (misalign_o)
   );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int XLEN        = 32,
   parameter int OFS_W       = 26,
   parameter int IMM_W       = 16,
   parameter int IDX_W       = 5,
   parameter int LINK_REG    = 31,
   parameter int INSTR_BYTES = 4,
   parameter int ALIGN_BITS  = 2
) (
   input logic [XLEN-1:0]  pc_i,
   input logic [OFS_W-1:0] offset_i,
   input logic [IMM_W-1:0] imm_i,
   input logic [XLEN-1:0]  rs1_i,
   input logic [2:0]       op_i,
   input logic [XLEN-1:0]  next_pc_o,
   input logic             taken_o,
   input logic             link_we_o,
   input logic [IDX_W-1:0] link_idx_o,
   input logic [XLEN-1:0]  link_val_o,
   input logic             misalign_o
);

   logic [XLEN-1:0] fall_thru;
   logic            fields_seen;

   assign fall_thru   = pc_i + XLEN'(INSTR_BYTES);
   assign fields_seen = ^{offset_i, imm_i};

   always_comb begin
      if (!taken_o)
         assert_fall_through_R1: assert (next_pc_o == fall_thru)
            else $error("untaken result does not fall through");
      if (op_i == 3'd1 || op_i == 3'd2)
         assert_jump_taken_R2: assert (taken_o)
            else $error("relative jump not taken");
      if (op_i == 3'd3 || op_i == 3'd4)
         assert_reg_target_R3: assert (taken_o && next_pc_o == rs1_i)
            else $error("register jump target wrong");
      if (op_i == 3'd5)
         assert_zero_branch_R4: assert (taken_o == (rs1_i == '0))
            else $error("branch-if-zero decision wrong");
      if (op_i == 3'd6)
         assert_nonzero_branch_R5: assert (taken_o == (rs1_i != '0))
            else $error("branch-if-nonzero decision wrong");
      assert_link_ops_R6: assert (link_we_o == (op_i == 3'd2 || op_i == 3'd4))
         else $error("link write on wrong operation");
      assert_link_fields_R6: assert (link_idx_o == IDX_W'(LINK_REG) && link_val_o == fall_thru)
         else $error("link index or value wrong");
      if (ALIGN_BITS > 0)
         assert_misalign_R7: assert (misalign_o == (taken_o && next_pc_o[1:0] != 2'b00))
            else $error("misaligned flag disagrees with target");
      if (op_i == 3'd7)
         assert_reserved_inert_R9: assert (!taken_o && !link_we_o && !misalign_o)
            else $error("reserved operation had an effect");
   end

   logic unused_chk;
   assign unused_chk = fields_seen;

endmodule

bind npc_unit npc_unit_chk #(
   .XLEN(XLEN), .OFS_W(OFS_W), .IMM_W(IMM_W), .IDX_W(IDX_W),
   .LINK_REG(LINK_REG), .INSTR_BYTES(INSTR_BYTES), .ALIGN_BITS(ALIGN_BITS)
) i_npc_unit_chk (.*);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

   logic        clk = 1'b0;
   logic [31:0] pc_i = '0, rs1_i = '0;
   logic [25:0] offset_i = '0;
   logic [15:0] imm_i = '0;
   logic [2:0]  op_i = '0;
   logic [31:0] next_pc_o, link_val_o;
   logic        taken_o, link_we_o, misalign_o;
   logic [4:0]  link_idx_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   npc_unit i_npc_unit (.*);

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h (op=%0d pc=%h rs1=%h)",
                  req, what, got, exp, op_i, pc_i, rs1_i);
      end
   endtask

   // Behavioural reference: evaluate one vector, compare every output.
   task automatic apply(input logic [2:0] op, input logic [31:0] pc,
                        input logic [25:0] ofs, input logic [15:0] imm,
                        input logic [31:0] rs1);
      longint seq, tgt;
      bit     tk, lk;
      string  rq;
      @(posedge clk); #1;
      op_i = op; pc_i = pc; offset_i = ofs; imm_i = imm; rs1_i = rs1;
      seq = (longint'(pc) + 4) % 64'h1_0000_0000;
      tgt = seq; tk = 0; lk = 0;
      case (op)
         3'd1, 3'd2: begin
            tgt = seq + longint'($signed(ofs)); tk = 1; rq = "R2";
         end
         3'd3, 3'd4: begin tgt = rs1; tk = 1; rq = "R3"; end
         3'd5: begin
            tk = (rs1 == 0); rq = "R4";
            if (tk) tgt = seq + longint'($signed(imm));
         end
         3'd6: begin
            tk = (rs1 != 0); rq = "R5";
            if (tk) tgt = seq + longint'($signed(imm));
         end
         3'd7: rq = "R9";
         default: rq = "R1";
      endcase
      lk = (op == 3'd2 || op == 3'd4);
      tgt = tgt & 64'hFFFF_FFFF;   // R8 wrap
      @(negedge clk);
      chk(rq, "next_pc", next_pc_o, tgt[31:0]);
      chk(rq, "taken", 32'(taken_o), 32'(tk));
      chk("R6", "link_we", 32'(link_we_o), 32'(lk));
      chk("R6", "link_idx", 32'(link_idx_o), 32'd31);
      chk("R6", "link_val", link_val_o, seq[31:0]);
      chk("R7", "misalign", 32'(misalign_o), 32'(tk && tgt[1:0] != 0));
   endtask

   initial begin
      #200_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 rest state and plain fall-through
      apply(3'd0, 32'h0000_1000, 26'h3FF_FFFF, 16'hFFFF, 32'h0);
      // R8 wrap of the sequential address
      apply(3'd0, 32'hFFFF_FFFC, 26'h0, 16'h0, 32'h5);
      // R2 forward, backward, extreme negative, wrap
      apply(3'd1, 32'h0000_2000, 26'h000_0100, 16'h0, 32'h0);
      apply(3'd1, 32'h0000_2000, 26'h3FF_FFF0, 16'h0, 32'h0);
      apply(3'd2, 32'h0400_0000, 26'h200_0000, 16'h0, 32'h0);
      apply(3'd2, 32'hFFFF_FFF8, 26'h000_0010, 16'h0, 32'h0);
      apply(3'd1, 32'h0000_0000, 26'h3FF_FFF0, 16'h0, 32'h0);
      // R2 R7 misaligned relative target
      apply(3'd1, 32'h0000_0100, 26'h000_0003, 16'h0, 32'h0);
      // R3 register jumps, aligned and misaligned
      apply(3'd3, 32'h0000_0040, 26'h0, 16'h0, 32'h8000_0000);
      apply(3'd4, 32'h0000_0040, 26'h0, 16'h0, 32'h1234_5676);
      apply(3'd3, 32'h0000_0040, 26'h0, 16'h0, 32'h0000_0001);
      // R4 branch-if-zero taken / not taken
      apply(3'd5, 32'h0000_3000, 26'h0, 16'h8000, 32'h0);
      apply(3'd5, 32'h0000_3000, 26'h0, 16'h0010, 32'h1);
      apply(3'd5, 32'h0000_0004, 26'h0, 16'h0002, 32'h0);
      // R5 branch-if-nonzero
      apply(3'd6, 32'h0000_3000, 26'h0, 16'h7FFC, 32'h8000_0000);
      apply(3'd6, 32'h0000_3000, 26'h0, 16'h0003, 32'h0);
      apply(3'd6, 32'hFFFF_FFF0, 26'h0, 16'h0020, 32'hFFFF_FFFF);
      // R9 reserved code inert even with misaligned fields
      apply(3'd7, 32'h0000_0010, 26'h000_0001, 16'h0001, 32'h3);
      // pseudo-random sweep over all codes
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         apply(3'(k % 8), $urandom, 26'($urandom), 16'($urandom),
               (r[3:0] == 0) ? 32'h0 : r);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule